// File: doc/BRIEF.md
# Misaligned Access Transfer Splitter

This block sits between a processor's load/store path and a 64-bit system data bus. It takes one access request at a time and turns it into one or two partial bus transfers. A request gives a byte address, a byte count, a direction flag and a space flag that selects memory or I/O. Each transfer the block emits names an 8-byte-aligned bus address and an 8-bit lane mask that marks the bytes taking part.

The point where an access has to be cut depends on its kind. Memory accesses and I/O reads are cut only where they cross an 8-byte line. I/O writes are also cut where they cross a 4-byte line, so both halves can fall inside the same 8-byte span. Requests of illegal size are dropped, and the block raises a one-cycle error flag for them. Both sides of the block use a valid/ready handshake. The request side closes while a transfer is still pending, so the second half of a split always follows the first with nothing in between.

Top module: `xfer_splitter`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, `xfer_valid` is 0 and `req_err` is 0.
- R2: Every transfer carries the request address with bits [2:0] cleared, and `xfer_write` and `xfer_io` copy the request's flags.
- R3: Bit i of `xfer_be` is 1 exactly when the byte at lane i (address bits [2:0] equal to i) belongs to that transfer. A request that needs no cut yields one transfer with `xfer_last` = 1.
- R4: A memory access or I/O read whose bytes cross an 8-byte line yields exactly two transfers. The lower part comes first, at the aligned address. The upper part comes second, at that address plus 8.
- R5: An I/O write whose bytes cross a 4-byte line yields exactly two transfers, lower bytes first. When both parts lie in one 8-byte span, both transfers carry the same address, the first with lanes below 4 and the second with lanes 4 to 7. An I/O transfer never enables more than 4 lanes.
- R6: An I/O read that crosses a 4-byte line but no 8-byte line yields a single transfer.
- R7: A request with a length of 0, a length above 8, or a length above 4 to I/O space raises `req_err` for one cycle, in the cycle after acceptance, and produces no transfer.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The first transfer appears in the next cycle. `req_ready` stays 0 until the last transfer of the request has been accepted. The second transfer of a split is presented in the cycle after the first is accepted. `xfer_last` is 1 only on the final transfer.
- R9: While `xfer_valid` is 1 and `xfer_ready` is 0, the transfer outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Byte address of the access |
| req_len | input | 4 | Byte count of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| xfer_valid | output | 1 | Transfer offered to the bus |
| xfer_ready | input | 1 | Bus takes the transfer |
| xfer_addr | output | 32 | 8-byte-aligned transfer address |
| xfer_be | output | 8 | Byte-lane enables |
| xfer_write | output | 1 | Direction of the transfer |
| xfer_io | output | 1 | Space of the transfer |
| xfer_last | output | 1 | Final transfer of the request |

## Verification
The error pulse for a rejected request and the acceptance of the next request can land in the same cycle, because a rejection never takes the block out of its idle state. The bench provokes this by holding `req_valid` high straight from an illegal request into a legal one. The cycle-level model must then show `req_err` high together with the new request being taken, and one cycle later the new request's first transfer with the error flag back at 0. A second overlap comes from random back-pressure on `xfer_ready` arriving while a split is pending. The model judges that `req_ready` stays low and that the stalled transfer holds its values until both halves have gone.

// File: rtl/xsplit_pkg.sv
`timescale 1ns/1ps
package xsplit_pkg;

   typedef enum logic [1:0] {
      SPL_IDLE   = 2'd0,
      SPL_FIRST  = 2'd1,
      SPL_SECOND = 2'd2
   } spl_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/xsplit_lane_mask.sv
`timescale 1ns/1ps
module xsplit_lane_mask #(
   parameter int BUS_BYTES = 8,
   parameter int SUM_W     = 5
) (
   input  logic [SUM_W-1:0]       lo,
   input  logic [SUM_W-1:0]       hi,
   input  logic [SUM_W-1:0]       cut,
   output logic [2*BUS_BYTES-1:0] span_m,
   output logic [BUS_BYTES-1:0]   below_m
);
   localparam int WIDE = 2 * BUS_BYTES;

   for (genvar i = 0; i < WIDE; i++) begin : g_span
      localparam logic [SUM_W-1:0] IDX = SUM_W'(i);
      assign span_m[i] = (IDX >= lo) && (IDX < hi);
   end

   for (genvar j = 0; j < BUS_BYTES; j++) begin : g_below
      localparam logic [SUM_W-1:0] JDX = SUM_W'(j);
      assign below_m[j] = (JDX < cut);
   end
endmodule

// File: rtl/xsplit_plan.sv
`timescale 1ns/1ps
module xsplit_plan #(
   parameter int ADDR_W       = 32,
   parameter int LEN_W        = 4,
   parameter int BUS_BYTES    = 8,
   parameter int IO_WR_SPAN   = 4,
   parameter int IO_MAX_BYTES = 4
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [LEN_W-1:0]     len,
   input  logic                 write,
   input  logic                 io,
   output logic                 bad,
   output logic                 split,
   output logic [ADDR_W-1:0]    addr0,
   output logic [ADDR_W-1:0]    addr1,
   output logic [BUS_BYTES-1:0] be0,
   output logic [BUS_BYTES-1:0] be1
);
   localparam int LANE_W = $clog2(BUS_BYTES);
   localparam int SUM_W  = ((LANE_W > LEN_W) ? LANE_W : LEN_W) + 1;
   localparam logic [SUM_W-1:0] BB_S   = SUM_W'(BUS_BYTES);
   localparam logic [SUM_W-1:0] IOW_S  = SUM_W'(IO_WR_SPAN);
   localparam logic [SUM_W-1:0] IOM_S  = SUM_W'(IO_MAX_BYTES);

   logic [LANE_W-1:0]      off;
   logic [ADDR_W-1:0]      base;
   logic [SUM_W-1:0]       off_x;
   logic [SUM_W-1:0]       len_x;
   logic [SUM_W-1:0]       end_pt;
   logic [SUM_W-1:0]       cut;
   logic [2*BUS_BYTES-1:0] span_m;
   logic [BUS_BYTES-1:0]   below_m;
   logic [BUS_BYTES-1:0]   span_lo;
   logic                   cut_at_line;

   assign off    = addr[LANE_W-1:0];
   assign base   = {addr[ADDR_W-1:LANE_W], LANE_W'(0)};
   assign off_x  = SUM_W'(off);
   assign len_x  = SUM_W'(len);
   assign end_pt = off_x + len_x;

   // Pick the cut point: the next boundary above the start lane.
   if (IO_WR_SPAN < BUS_BYTES) begin : g_io_narrow
      always_comb begin
         if (io && write) cut = (off_x & ~(IOW_S - SUM_W'(1))) + IOW_S;
         else             cut = BB_S;
      end
   end else begin : g_io_uniform
      assign cut = BB_S;
   end

   xsplit_lane_mask #(
      .BUS_BYTES (BUS_BYTES),
      .SUM_W     (SUM_W)
   ) u_mask (
      .lo      (off_x),
      .hi      (end_pt),
      .cut     (cut),
      .span_m  (span_m),
      .below_m (below_m)
   );

   assign span_lo     = span_m[BUS_BYTES-1:0];
   assign cut_at_line = (cut == BB_S);

   assign bad   = (len_x == '0) || (len_x > BB_S) || (io && (len_x > IOM_S));
   assign split = (end_pt > cut);
   assign addr0 = base;
   assign addr1 = cut_at_line ? (base + ADDR_W'(BUS_BYTES)) : base;
   assign be0   = span_lo & below_m;
   assign be1   = cut_at_line ? span_m[2*BUS_BYTES-1:BUS_BYTES] : (span_lo & ~below_m);
endmodule

// File: rtl/xsplit_ctrl.sv
`timescale 1ns/1ps
module xsplit_ctrl
   import xsplit_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BUS_BYTES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 bad,
   input  logic                 split,
   input  logic [ADDR_W-1:0]    addr0,
   input  logic [ADDR_W-1:0]    addr1,
   input  logic [BUS_BYTES-1:0] be0,
   input  logic [BUS_BYTES-1:0] be1,
   input  logic                 write,
   input  logic                 io,
   output logic                 err_pulse,
   output logic                 xfer_valid,
   input  logic                 xfer_ready,
   output logic [ADDR_W-1:0]    xfer_addr,
   output logic [BUS_BYTES-1:0] xfer_be,
   output logic                 xfer_write,
   output logic                 xfer_io,
   output logic                 xfer_last
);
   localparam int LANE_W = $clog2(BUS_BYTES);

   spl_state_e             state_q;
   logic [ADDR_W-1:0]      out_addr_q, hold_addr_q;
   logic [BUS_BYTES-1:0]   out_be_q, hold_be_q;
   logic                   out_last_q, out_wr_q, out_io_q, err_q;
   logic                   accept;

   assign req_ready = (state_q == SPL_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= SPL_IDLE;
         out_addr_q  <= '0;
         hold_addr_q <= '0;
         out_be_q    <= '0;
         hold_be_q   <= '0;
         out_last_q  <= 1'b0;
         out_wr_q    <= 1'b0;
         out_io_q    <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         err_q <= accept && bad;
         unique case (state_q)
            SPL_IDLE: begin
               if (accept && !bad) begin
                  out_addr_q  <= addr0;
                  out_be_q    <= be0;
                  out_last_q  <= !split;
                  hold_addr_q <= addr1;
                  hold_be_q   <= be1;
                  out_wr_q    <= write;
                  out_io_q    <= io;
                  state_q     <= SPL_FIRST;
               end
            end
            SPL_FIRST: begin
               if (xfer_ready) begin
                  if (out_last_q) begin
                     state_q <= SPL_IDLE;
                  end else begin
                     out_addr_q <= hold_addr_q;
                     out_be_q   <= hold_be_q;
                     out_last_q <= 1'b1;
                     state_q    <= SPL_SECOND;
                  end
               end
            end
            SPL_SECOND: begin
               if (xfer_ready) state_q <= SPL_IDLE;
            end
            default: state_q <= SPL_IDLE;
         endcase
      end
   end

   assign xfer_valid = (state_q != SPL_IDLE);
   assign xfer_addr  = out_addr_q;
   assign xfer_be    = out_be_q;
   assign xfer_write = out_wr_q;
   assign xfer_io    = out_io_q;
   assign xfer_last  = out_last_q;
   assign err_pulse  = err_q;

   // R2: emitted addresses are always bus aligned
   assert_aligned_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> (xfer_addr[LANE_W-1:0] == '0));

   // R3: a transfer always moves at least one byte
   assert_lanes_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> (xfer_be != '0));

   // R7: a rejected request leaves the bus side idle
   assert_err_no_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> !xfer_valid);

   // R8: request side stays closed while any transfer is pending
   assert_stall_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> !req_ready);

   // R8: accepted first half is followed at once by the final half
   assert_second_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready && !xfer_last) |=> (xfer_valid && xfer_last));

   // R9: a stalled transfer holds its contents
   assert_hold_stalled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr)
         && $stable(xfer_be) && $stable(xfer_last) && $stable(xfer_write) && $stable(xfer_io)));
endmodule

// File: rtl/xfer_splitter.sv
`timescale 1ns/1ps
module xfer_splitter
   import xsplit_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int LEN_W        = 4,
   parameter int BUS_BYTES    = 8,
   parameter int IO_WR_SPAN   = 4,
   parameter int IO_MAX_BYTES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [LEN_W-1:0]     req_len,
   input  logic                 req_write,
   input  logic                 req_io,
   output logic                 req_err,
   output logic                 xfer_valid,
   input  logic                 xfer_ready,
   output logic [ADDR_W-1:0]    xfer_addr,
   output logic [BUS_BYTES-1:0] xfer_be,
   output logic                 xfer_write,
   output logic                 xfer_io,
   output logic                 xfer_last
);
   if (!is_pow2(BUS_BYTES) || BUS_BYTES < 2) begin : g_bad_bus
      $error("BUS_BYTES must be a power of two of at least 2");
   end
   if (!is_pow2(IO_WR_SPAN) || IO_WR_SPAN > BUS_BYTES) begin : g_bad_span
      $error("IO_WR_SPAN must be a power of two no larger than BUS_BYTES");
   end
   if (IO_MAX_BYTES < 1 || IO_MAX_BYTES > IO_WR_SPAN) begin : g_bad_iomax
      $error("IO_MAX_BYTES must lie in 1..IO_WR_SPAN");
   end
   if ((1 << LEN_W) <= BUS_BYTES) begin : g_bad_len
      $error("LEN_W too narrow to encode a full bus width");
   end
   if (ADDR_W <= $clog2(BUS_BYTES)) begin : g_bad_addr
      $error("ADDR_W too narrow");
   end

   logic                 p_bad, p_split;
   logic [ADDR_W-1:0]    p_addr0, p_addr1;
   logic [BUS_BYTES-1:0] p_be0, p_be1;

   xsplit_plan #(
      .ADDR_W       (ADDR_W),
      .LEN_W        (LEN_W),
      .BUS_BYTES    (BUS_BYTES),
      .IO_WR_SPAN   (IO_WR_SPAN),
      .IO_MAX_BYTES (IO_MAX_BYTES)
   ) u_plan (
      .addr  (req_addr),
      .len   (req_len),
      .write (req_write),
      .io    (req_io),
      .bad   (p_bad),
      .split (p_split),
      .addr0 (p_addr0),
      .addr1 (p_addr1),
      .be0   (p_be0),
      .be1   (p_be1)
   );

   xsplit_ctrl #(
      .ADDR_W    (ADDR_W),
      .BUS_BYTES (BUS_BYTES)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .bad        (p_bad),
      .split      (p_split),
      .addr0      (p_addr0),
      .addr1      (p_addr1),
      .be0        (p_be0),
      .be1        (p_be1),
      .write      (req_write),
      .io         (req_io),
      .err_pulse  (req_err),
      .xfer_valid (xfer_valid),
      .xfer_ready (xfer_ready),
      .xfer_addr  (xfer_addr),
      .xfer_be    (xfer_be),
      .xfer_write (xfer_write),
      .xfer_io    (xfer_io),
      .xfer_last  (xfer_last)
   );

   // R5: an I/O transfer never enables more lanes than the I/O size limit
   assert_io_lane_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_io) |-> ($countones(xfer_be) <= IO_MAX_BYTES));
endmodule

// File: tb/xfer_splitter_tb_top.sv
`timescale 1ns/1ps
module xfer_splitter_tb_top;

   typedef struct {
      logic [31:0] a;
      logic [7:0]  be;
      bit          last;
      bit          wr;
      bit          io;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_len = '0;
   logic        req_write = 1'b0;
   logic        req_io = 1'b0;
   logic        xfer_ready = 1'b1;
   logic        req_ready, req_err, xfer_valid, xfer_write, xfer_io, xfer_last;
   logic [31:0] xfer_addr;
   logic [7:0]  xfer_be;

   int   n_chk = 0;
   int   n_err = 0;
   bit   run = 1'b0;
   bit   done = 1'b0;
   int   stall_mode = 0;
   exp_t exp_q[$];
   bit   err_exp = 1'b0;

   always #4 clk = ~clk;

   xfer_splitter dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_len(req_len), .req_write(req_write), .req_io(req_io), .req_err(req_err),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
      .xfer_be(xfer_be), .xfer_write(xfer_write), .xfer_io(xfer_io), .xfer_last(xfer_last)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural plan: walk the bytes, open a new transfer whenever the
   // splitting chunk changes (4-byte chunks for I/O writes, 8-byte otherwise).
   function automatic void plan(input logic [31:0] addr, input int len, input bit wr, input bit io);
      longint prev = -1;
      for (int k = 0; k < len; k++) begin
         longint x = longint'(addr) + k;
         longint key = (io && wr) ? (x >> 2) : (x >> 3);
         if (key != prev) begin
            exp_t e;
            e.a = 32'(x) & ~32'h7;
            e.be = '0; e.last = 1'b0; e.wr = wr; e.io = io;
            exp_q.push_back(e);
            prev = key;
         end
         exp_q[exp_q.size()-1].be[32'(x) % 8] = 1'b1;
      end
      exp_q[exp_q.size()-1].last = 1'b1;
   endfunction

   // Cycle reference model: compare, then advance with this cycle's inputs.
   always @(negedge clk) begin
      if (run && !done) begin
         bit busy;
         bit nxt_err;
         busy = (exp_q.size() > 0);
         chk("R8 req_ready", 32'(req_ready), 32'(!busy));
         chk("R8 xfer_valid", 32'(xfer_valid), 32'(busy));
         chk("R7 req_err", 32'(req_err), 32'(err_exp));
         if (busy && xfer_valid) begin
            chk("R2 xfer_addr", xfer_addr, exp_q[0].a);
            chk("R3 xfer_be", 32'(xfer_be), 32'(exp_q[0].be));
            chk("R8 xfer_last", 32'(xfer_last), 32'(exp_q[0].last));
            chk("R2 xfer_write", 32'(xfer_write), 32'(exp_q[0].wr));
            chk("R2 xfer_io", 32'(xfer_io), 32'(exp_q[0].io));
         end
         nxt_err = 1'b0;
         if (!busy && req_valid) begin
            int l;
            l = int'(req_len);
            if (l == 0 || l > 8 || (req_io && l > 4)) nxt_err = 1'b1;
            else plan(req_addr, l, req_write, req_io);
         end else if (busy && xfer_ready) begin
            void'(exp_q.pop_front());
         end
         err_exp = nxt_err;
      end
   end

   // Back-pressure driver (R9 exercised when stall_mode != 0)
   initial begin
      forever begin
         @(posedge clk); #1;
         if (stall_mode == 0) xfer_ready = 1'b1;
         else                 xfer_ready = ($urandom % 3) != 0;
      end
   end

   task automatic issue(input logic [31:0] a, input int len, input bit wr, input bit io, input bit hold);
      if (!req_ready) begin
         req_valid = 1'b0;
         while (!req_ready) begin @(posedge clk); #1; end
      end
      req_valid = 1'b1;
      req_addr  = a;
      req_len   = 4'(len);
      req_write = wr;
      req_io    = io;
      @(posedge clk); #1;
      if (!hold) req_valid = 1'b0;
   endtask

   task automatic drain();
      req_valid = 1'b0;
      repeat (2) @(posedge clk);
      while (!req_ready || xfer_valid) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: state while reset is held
      chk("R1 req_ready in reset", 32'(req_ready), 32'd1);
      chk("R1 xfer_valid in reset", 32'(xfer_valid), 32'd0);
      chk("R1 req_err in reset", 32'(req_err), 32'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
      chk("R1 xfer_valid after reset", 32'(xfer_valid), 32'd0);
      run = 1'b1;

      // R3: aligned full line and small unsplit access
      issue(32'h0000_0100, 8, 1'b0, 1'b0, 1'b0);
      issue(32'h0000_0103, 2, 1'b1, 1'b0, 1'b0);
      // R4: misaligned 8-byte memory read, I/O read over an 8-byte line
      issue(32'h0000_0205, 8, 1'b0, 1'b0, 1'b0);
      issue(32'h0000_0306, 4, 1'b0, 1'b1, 1'b0);
      // R6: I/O read over a 4-byte line only
      issue(32'h0000_0402, 4, 1'b0, 1'b1, 1'b0);
      // R5: I/O writes over 4-byte line, same span and across span
      issue(32'h0000_0402, 4, 1'b1, 1'b1, 1'b0);
      issue(32'h0000_0506, 3, 1'b1, 1'b1, 1'b0);
      issue(32'h0000_0504, 4, 1'b1, 1'b1, 1'b0);
      // R7: illegal sizes, each held straight into a legal request
      issue(32'h0000_0600, 0, 1'b0, 1'b0, 1'b1);
      issue(32'h0000_0607, 2, 1'b0, 1'b0, 1'b1);
      issue(32'h0000_0700, 9, 1'b1, 1'b0, 1'b1);
      issue(32'h0000_0701, 5, 1'b0, 1'b1, 1'b1);
      issue(32'h0000_0703, 4, 1'b1, 1'b1, 1'b0);
      drain();

      // R9: random back-pressure with splits pending
      stall_mode = 1;
      issue(32'h0000_0805, 8, 1'b1, 1'b0, 1'b0);
      issue(32'h0000_0903, 3, 1'b1, 1'b1, 1'b0);
      drain();

      // Mixed random traffic, held and released valid
      for (int n = 0; n < 600; n++) begin
         stall_mode = ($urandom % 2);
         issue({17'd0, 15'($urandom)}, int'($urandom % 11), 1'($urandom), 1'($urandom),
               1'($urandom));
      end
      drain();
      stall_mode = 0;
      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule